// File: doc/BRIEF.md
# Addressed Serial Four-Channel Converter Register Loader

This block is the digital front end of a four-channel 14-bit converter that can share one serial bus with up to 31 other copies of itself. A host sends 24-bit write frames on a serial data line. Each bit is sampled on a falling shift-clock edge while an active-low frame strobe is held low. The block runs on its own system clock and samples all serial and strobe pins through two-stage synchronizers. It treats a shift-clock falling edge as a sample event.

A complete frame carries a channel number, a 5-bit package address and a 14-bit code. The package address must match the strapped address pins, unless the bypass pin is high. When a frame is accepted, its code goes into the selected channel's input register. An active-low load strobe decides when input registers reach the output latches. Held high, it makes writes wait. Its falling edge copies all four at once. Held low, it lets each accepted write update its own latch straight away. An asynchronous active-low clear empties every output latch and raises a cleared flag. The input registers keep their contents through a clear.

Top module: `quad_dac_loader`

## Requirements
- R1: A frame is the first 24 bits sampled, MSB first, on `ser_clk` falling edges while `frame_n` is low. The bit count restarts on each falling edge of `frame_n`. Further `ser_clk` edges in the same frame are ignored.
- R2: Frame bit positions are fixed. Bits 23:22 give the channel (00 selects channel 0 at `latch_codes[13:0]`, up to 11 for channel 3 at `latch_codes[55:42]`). Bit 21 is ignored. Bits 20:16 hold the package address. Bits 15:14 are ignored. Bits 13:0 hold the code.
- R3: A complete frame is accepted only when its package address equals `dev_addr`, or when `addr_bypass` is high. Any other frame leaves every register unchanged.
- R4: If `frame_n` rises before 24 bits have been sampled, the partial frame is dropped and no register changes.
- R5: While `load_n` is high, an accepted frame writes only the input register of its channel. All latch outputs keep their values.
- R6: A high-to-low transition of `load_n` copies all four input registers into their latches together.
- R7: While `load_n` is low, an accepted frame updates both the input register and the latch of its own channel. The update happens within 6 `clk` cycles of the 24th bit's falling `ser_clk` edge. The other three latches do not change.
- R8: Driving `clear_n` low sets every latch to zero at once, with no `clk` edge needed. The latches stay at zero while `clear_n` is low. Input registers keep their contents, so a later `load_n` falling edge restores them.
- R9: `cleared` is high after reset or a clear. It falls on the first latch load after the clear has been released.
- R10: After `rst_n` is released, all latches read zero and `cleared` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample all serial inputs |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ser_clk | input | 1 | Serial shift clock; data is taken on its falling edge |
| frame_n | input | 1 | Active-low frame strobe |
| ser_dat | input | 1 | Serial data, MSB first |
| load_n | input | 1 | Active-low latch load strobe |
| clear_n | input | 1 | Asynchronous active-low clear of all latches |
| dev_addr | input | 5 | Strapped package address |
| addr_bypass | input | 1 | High: accept frames for any package address |
| latch_codes | output | 56 | Four 14-bit latch values, channel 0 in the low bits |
| cleared | output | 1 | High while the latches hold the clear state |

## Verification
The assertions assume that every serial and strobe input holds each level for at least three `clk` cycles. They also assume that `frame_n` never falls in the same sampled cycle as a `ser_clk` falling edge. The address pins and `addr_bypass` must stay constant during a frame, and `load_n` is never toggled while a frame is in flight. The stimulus keeps within these limits. It holds each shift-clock half period for five `clk` cycles and changes data only while the shift clock is high. It changes the bypass pin and the load level only between frames, and asserts the clear only with the bus idle. Random frames still vary channel, address match, ignored bits, load mode and frame length, covering short and over-long frames.

// File: rtl/qdl_pkg.sv
package qdl_pkg;
  parameter int FRAME_BITS = 24;
  parameter int CODE_W     = 14;
  parameter int ADDR_W     = 5;
  parameter int NCH        = 4;
  parameter int CH_W       = $clog2(NCH);
  parameter int LEAD_W     = 2;

  typedef struct packed {
    logic [CH_W-1:0]   chan;
    logic              spare;
    logic [ADDR_W-1:0] addr;
    logic [LEAD_W-1:0] lead;
    logic [CODE_W-1:0] code;
  } frame_t;
endpackage

// File: rtl/qdl_rst_sync.sv
module qdl_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stg;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg <= 2'b00;
    else         stg <= {stg[0], 1'b1};
  end

  assign srst_n = stg[1];
endmodule

// File: rtl/qdl_sync.sv
module qdl_sync #(
  parameter int          W      = 4,
  parameter logic [W-1:0] RST_V = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;
  logic [W-1:0] s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= RST_V;
      s2 <= RST_V;
    end else begin
      s1 <= d;
      s2 <= s1;
    end
  end

  assign q = s2;
endmodule

// File: rtl/qdl_shifter.sv
module qdl_shifter
  import qdl_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sclk_s,
  input  logic   frame_s,
  input  logic   dat_s,
  output logic   done,
  output frame_t frame
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_BITS);

  logic                  sclk_q, frame_q;
  logic [CNT_W-1:0]      cnt, cnt_nx;
  logic [FRAME_BITS-1:0] sh, sh_nx;
  logic                  done_nx;
  logic                  sclk_fall, frame_fall;

  assign sclk_fall  = sclk_q & ~sclk_s;
  assign frame_fall = frame_q & ~frame_s;

  always_comb begin
    cnt_nx  = cnt;
    sh_nx   = sh;
    done_nx = 1'b0;
    if (frame_fall) begin
      cnt_nx = '0;
    end else if (!frame_s && sclk_fall && cnt < FULL) begin
      sh_nx  = {sh[FRAME_BITS-2:0], dat_s};
      cnt_nx = cnt + 1'b1;
      if (cnt == LAST) done_nx = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b1;
      frame_q <= 1'b1;
      cnt     <= FULL;
      sh      <= '0;
      done    <= 1'b0;
    end else begin
      sclk_q  <= sclk_s;
      frame_q <= frame_s;
      cnt     <= cnt_nx;
      sh      <= sh_nx;
      done    <= done_nx;
    end
  end

  assign frame = frame_t'(sh);

  // R1: the bit counter never passes the frame length
  a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n) cnt <= FULL);
  // R1: one completion pulse per frame
  a_r1_single_done: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
endmodule

// File: rtl/qdl_bank.sv
module qdl_bank
  import qdl_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  lat_rst_n,
  input  logic                  wr_en,
  input  logic [CH_W-1:0]       wr_ch,
  input  logic [CODE_W-1:0]     wr_code,
  input  logic                  load_s,
  output logic [NCH*CODE_W-1:0] codes,
  output logic                  cleared
);
  logic [CODE_W-1:0] inreg [NCH];
  logic [CODE_W-1:0] in_nx [NCH];
  logic [CODE_W-1:0] lat   [NCH];
  logic [CODE_W-1:0] lat_nx[NCH];
  logic [NCH-1:0]    upd;
  logic              load_q, load_all, any_load, cleared_nx;

  assign load_all = load_q & ~load_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) load_q <= 1'b1;
    else        load_q <= load_s;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_comb begin
      upd[i]    = wr_en && (wr_ch == CH_W'(i)) && !load_s;
      in_nx[i]  = (wr_en && (wr_ch == CH_W'(i))) ? wr_code : inreg[i];
      lat_nx[i] = lat[i];
      if (load_all)    lat_nx[i] = in_nx[i];
      else if (upd[i]) lat_nx[i] = wr_code;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) inreg[i] <= '0;
      else        inreg[i] <= in_nx[i];
    end

    always_ff @(posedge clk or negedge lat_rst_n) begin
      if (!lat_rst_n) lat[i] <= '0;
      else            lat[i] <= lat_nx[i];
    end

    assign codes[i*CODE_W +: CODE_W] = lat[i];

    // R5: with no load of any kind the latch holds its value
    a_r5_hold: assert property (@(posedge clk) disable iff (!lat_rst_n)
      (!load_all && !(|upd)) |=> $stable(lat[i]));
    // R7: a single-channel update leaves the other latches alone
    a_r7_other_stable: assert property (@(posedge clk) disable iff (!lat_rst_n)
      (!load_all && (|upd) && !upd[i]) |=> $stable(lat[i]));
  end

  assign any_load   = load_all | (|upd);
  assign cleared_nx = any_load ? 1'b0 : cleared;

  always_ff @(posedge clk or negedge lat_rst_n) begin
    if (!lat_rst_n) cleared <= 1'b1;
    else            cleared <= cleared_nx;
  end

  // R7: at most one channel takes a direct write
  a_r7_onehot: assert property (@(posedge clk) disable iff (!lat_rst_n) $onehot0(upd));
  // R9: any latch load drops the cleared flag
  a_r9_flag_drop: assert property (@(posedge clk) disable iff (!lat_rst_n) any_load |=> !cleared);
endmodule

// File: rtl/quad_dac_loader.sv
module quad_dac_loader
  import qdl_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ser_clk,
  input  logic                  frame_n,
  input  logic                  ser_dat,
  input  logic                  load_n,
  input  logic                  clear_n,
  input  logic [ADDR_W-1:0]     dev_addr,
  input  logic                  addr_bypass,
  output logic [NCH*CODE_W-1:0] latch_codes,
  output logic                  cleared
);
  logic   sys_rst_n, lat_rst_n, clr_src_n;
  logic   sclk_s, frame_s, dat_s, load_s;
  logic   done, accept;
  frame_t frame;

  assign clr_src_n = rst_n & clear_n;

  qdl_rst_sync u_rst (.clk(clk), .arst_n(rst_n),     .srst_n(sys_rst_n));
  qdl_rst_sync u_clr (.clk(clk), .arst_n(clr_src_n), .srst_n(lat_rst_n));

  qdl_sync #(.W(4), .RST_V(4'b1101)) u_sync (
    .clk(clk), .rst_n(sys_rst_n),
    .d({ser_clk, frame_n, ser_dat, load_n}),
    .q({sclk_s, frame_s, dat_s, load_s})
  );

  qdl_shifter u_shift (
    .clk(clk), .rst_n(sys_rst_n), .sclk_s(sclk_s), .frame_s(frame_s),
    .dat_s(dat_s), .done(done), .frame(frame)
  );

  assign accept = done && (addr_bypass || (frame.addr == dev_addr));

  qdl_bank u_bank (
    .clk(clk), .rst_n(sys_rst_n), .lat_rst_n(lat_rst_n),
    .wr_en(accept), .wr_ch(frame.chan), .wr_code(frame.code),
    .load_s(load_s), .codes(latch_codes), .cleared(cleared)
  );

  // R8: while the clear pin is low every latch reads zero
  a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_n |-> (latch_codes == '0 && cleared));
endmodule

// File: tb/sim_quad_dac_loader.sv
module sim_quad_dac_loader;
  localparam int HALF = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, ser_clk, frame_n, ser_dat, load_n, clear_n, addr_bypass;
  logic [4:0]  dev_addr;
  logic [55:0] latch_codes;
  logic        cleared;

  quad_dac_loader u0 (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .frame_n(frame_n),
    .ser_dat(ser_dat), .load_n(load_n), .clear_n(clear_n),
    .dev_addr(dev_addr), .addr_bypass(addr_bypass),
    .latch_codes(latch_codes), .cleared(cleared)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [13:0] in_ref [4];
  logic [13:0] lat_ref[4];
  logic        clr_ref;
  logic        load_lvl;

  function automatic logic [23:0] mk(input logic [1:0] ch, input logic sp,
                                     input logic [4:0] ad, input logic [1:0] ld,
                                     input logic [13:0] cd);
    return {ch, sp, ad, ld, cd};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    for (int i = 0; i < 4; i++) chk(tag, 32'(latch_codes[i*14 +: 14]), 32'(lat_ref[i]));
    chk(tag, 32'(cleared), 32'(clr_ref));
  endtask

  task automatic send(input logic [23:0] f, input int n);
    @(negedge clk) frame_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      ser_dat = (i < 24) ? f[23-i] : 1'($urandom);
      repeat (HALF) @(negedge clk);
      ser_clk = 1'b0;
      repeat (HALF) @(negedge clk);
      ser_clk = 1'b1;
    end
    repeat (HALF) @(negedge clk);
    frame_n = 1'b1;
    repeat (2*HALF) @(negedge clk);
    if (n >= 24 && (addr_bypass || f[20:16] == dev_addr)) begin
      in_ref[f[23:22]] = f[13:0];
      if (!load_lvl) begin
        lat_ref[f[23:22]] = f[13:0];
        clr_ref = 1'b0;
      end
    end
  endtask

  task automatic set_load(input logic v);
    if (load_lvl && !v) begin
      for (int i = 0; i < 4; i++) lat_ref[i] = in_ref[i];
      clr_ref = 1'b0;
    end
    load_lvl = v;
    @(negedge clk) load_n = v;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R1 watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0; clear_n = 1'b1; load_n = 1'b1; frame_n = 1'b1;
    ser_clk = 1'b1; ser_dat = 1'b0; dev_addr = 5'h13; addr_bypass = 1'b0;
    for (int i = 0; i < 4; i++) begin in_ref[i] = '0; lat_ref[i] = '0; end
    clr_ref = 1'b1; load_lvl = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check_all("R10");

    // per-write mode, channel 2
    set_load(1'b0);
    check_all("R6");
    send(mk(2'b10, 1'b0, 5'h13, 2'b00, 14'h2A5C), 24);
    check_all("R7");
    send(mk(2'b11, 1'b0, 5'h13, 2'b00, 14'h3FFF), 24);
    check_all("R2");

    // hold mode then block load
    set_load(1'b1);
    send(mk(2'b00, 1'b0, 5'h13, 2'b00, 14'h0111), 24);
    send(mk(2'b01, 1'b0, 5'h13, 2'b00, 14'h1234), 24);
    check_all("R5");
    set_load(1'b0);
    check_all("R6");

    // address mismatch, then bypass
    send(mk(2'b01, 1'b0, 5'h0C, 2'b00, 14'h0F0F), 24);
    check_all("R3");
    addr_bypass = 1'b1;
    send(mk(2'b01, 1'b0, 5'h0C, 2'b00, 14'h0F0F), 24);
    check_all("R3");
    addr_bypass = 1'b0;

    // partial and over-long frames
    send(mk(2'b00, 1'b0, 5'h13, 2'b00, 14'h3333), 20);
    check_all("R4");
    send(mk(2'b00, 1'b0, 5'h13, 2'b00, 14'h0ABC), 26);
    check_all("R1");

    // ignored bits set
    send(mk(2'b10, 1'b1, 5'h13, 2'b11, 14'h0001), 24);
    check_all("R2");

    // asynchronous clear between clock edges
    @(negedge clk);
    #1 clear_n = 1'b0;
    for (int i = 0; i < 4; i++) lat_ref[i] = '0;
    clr_ref = 1'b1;
    #2 check_all("R8");
    repeat (4) @(negedge clk);
    check_all("R8");
    clear_n = 1'b1;
    repeat (6) @(negedge clk);
    check_all("R9");
    set_load(1'b1);
    set_load(1'b0);
    check_all("R8");
    check_all("R9");

    // random frames
    for (int it = 0; it < 60; it++) begin
      string tag;
      logic [4:0] ad;
      int n;
      if ($urandom % 5 == 0) set_load(~load_lvl);
      if ($urandom % 8 == 0) addr_bypass = ~addr_bypass;
      ad = ($urandom % 2 == 0) ? dev_addr : 5'($urandom);
      n = ($urandom % 6 == 0) ? int'($urandom % 24) : 24 + (($urandom % 4 == 0) ? int'($urandom % 3) : 0);
      tag = (n < 24) ? "R4" : (load_lvl ? "R5" : "R7");
      send(mk(2'($urandom), 1'($urandom), ad, 2'($urandom), 14'($urandom)), n);
      check_all(tag);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule